// File: doc/BRIEF.md
# Codec mode-change and calibration sequencer

This block is the control sequencer behind an audio codec's indexed host register port. It holds the configuration the host writes (a control byte with a mode-change-enable bit, an auto-calibrate bit, a resync-bypass bit and a frequency-select enable), the clock selection byte and two frequency-select bytes. From these writes and a one-cycle sample-period tick it runs two timed activities. The first is an offset calibration phase. It runs by itself after reset, and again when the host leaves mode-change-enable with auto-calibrate set. The second is a resynchronization window that follows any change of the clock selection.

While calibration is active, the block withholds readiness on the transfer handshake, marks converter output samples invalid and refuses converter input samples. At the end of calibration it pulses a load strobe that writes new left and right offset values into the offset store. A stub counter stands in for the measured offsets. While a resync window is open, host writes are thrown away and every read returns the sentinel 0x80. In basic (compatibility) mode, rate changes go through the clock selection byte only. In expanded mode the two frequency bytes can be rewritten while the codec runs.

Register indices (3-bit `reg_idx`): 0 control (bit0 mode-change enable, bit1 auto-calibrate, bit2 resync bypass, bit3 frequency-select enable), 1 clock selection (bits 2:0 divider, bit3 source), 2 frequency high byte, 3 frequency low byte, 4 status (bit5 calibration busy, other bits zero), 5 left offset, 6 right offset, 7 reads zero. Unused upper bits read as zero.

Top module: `codec_modeseq`

## Requirements
- R1: Leaving reset starts a calibration with no host action. At its end, the left offset (index 5) reads 1 and the right offset (index 6) reads 0xFE.
- R2: A control write that clears bit0 while the stored bit0 is 1 and the written bit1 is 1 starts calibration. No other control write does, and then the offset readbacks stay unchanged.
- R3: After a calibration trigger, `cal_busy` rises after exactly ARM_TICKS sample ticks (ARM_TICKS is at most 5). It then stays high for exactly CAL_TICKS sample ticks (384 by default) and falls.
- R4: From the trigger until calibration ends, `xfer_ready` is low, so `xfer_fire` (valid and ready together) cannot occur. A requester must hold `xfer_valid` until `xfer_ready`. Once calibration is over, `xfer_ready` is high again.
- R5: While calibration is active, `adc_out_valid` and `dac_take` are low whatever `adc_smp_valid` and `dac_smp_valid` do. Outside calibration they follow those inputs.
- R6: An accepted write to index 1 whose low nibble differs from the stored one, made while bit2 of control is 0, opens a resync window lasting RESYNC_TICKS sample ticks. During it `resync_busy` is high, every read returns 0x80 and every write is dropped.
- R7: With control bit2 set, a clock selection change opens no window. A write of the same clock selection never opens one.
- R8: The frequency bytes (indices 2 and 3) take a write only when `compat_mode` is 0 and control bit3 is 1. Such writes start neither calibration nor a resync window.
- R9: With `compat_mode` high, writes to indices 2 and 3 are ignored.
- R10: `off_load` is high for exactly one cycle, the cycle right after `cal_busy` falls. In that cycle `off_left` holds the count of completed calibrations (modulo 2^OFF_W) and `off_right` holds its bitwise inverse.
- R11: Reads of indices 0, 1 and 4 return the stored control bits, the stored clock selection and the busy flag at bit5, with unused bits zero. After reset, control and clock selection are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_tick | input | 1 | One-cycle pulse per sample period |
| compat_mode | input | 1 | 1 selects basic mode (frequency bytes locked) |
| wr_en | input | 1 | Host register write strobe |
| reg_idx | input | 3 | Register index for write and read |
| wr_data | input | DATA_W | Host write data |
| rd_data | output | DATA_W | Read data for `reg_idx` (combinational) |
| xfer_valid | input | 1 | Data transfer request |
| xfer_ready | output | 1 | Transfer may start; low during calibration |
| xfer_fire | output | 1 | Transfer starts this cycle |
| adc_smp_valid | input | 1 | Converter produced an output sample |
| adc_out_valid | output | 1 | Output sample is valid |
| dac_smp_valid | input | 1 | Input sample offered to the converter |
| dac_take | output | 1 | Input sample accepted |
| cal_busy | output | 1 | Calibration in progress flag |
| resync_busy | output | 1 | Resync window open |
| off_load | output | 1 | One-cycle offset store load strobe |
| off_left | output | OFF_W | Left offset value |
| off_right | output | OFF_W | Right offset value |

## Verification
The bench builds the block with CAL_TICKS=12, ARM_TICKS=3 and RESYNC_TICKS=5, and drives a sample tick every fourth clock. With these values a calibration lasts about sixty cycles, so several calibrations fit in one run. The bench walks all eight combinations of previous mode-change bit, new mode-change bit and auto-calibrate bit, and counts the arming and busy ticks exactly for each trigger. It steps the clock selection through all sixteen values, with a window expected on every change, and crosses basic/expanded mode with the frequency enable for the frequency bytes.

// File: rtl/codec_modeseq_pkg.sv
package codec_modeseq_pkg;

  typedef enum logic [2:0] {
    IDX_CTRL = 3'd0,
    IDX_CLK  = 3'd1,
    IDX_FHI  = 3'd2,
    IDX_FLO  = 3'd3,
    IDX_STAT = 3'd4,
    IDX_OFFL = 3'd5,
    IDX_OFFR = 3'd6,
    IDX_NONE = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_ARM  = 2'd1,
    CAL_RUN  = 2'd2
  } cal_state_e;

  // control byte, low nibble
  typedef struct packed {
    logic freq_en;    // bit3
    logic init_skip;  // bit2
    logic acal_en;    // bit1
    logic mce;        // bit0
  } ctrl_t;

  localparam int CTRL_W   = 4;
  localparam int CLKSEL_W = 4;
  localparam int STAT_BUSY_BIT = 5;
  localparam logic [7:0] SENTINEL = 8'h80;

endpackage

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_modeseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_idx_e          wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              compat_mode,
  input  logic              resync_busy,
  output ctrl_t             ctrl_q,
  output logic [CLKSEL_W-1:0] clk_sel_q,
  output logic [DATA_W-1:0] freq_hi_q,
  output logic [DATA_W-1:0] freq_lo_q,
  output logic              cal_req,
  output logic              resync_req
);

  logic  wr_ok;
  logic  freq_ok;
  ctrl_t ctrl_new;
  logic [CLKSEL_W-1:0] clk_new;

  assign wr_ok    = wr_en && !resync_busy;
  assign freq_ok  = wr_ok && !compat_mode && ctrl_q.freq_en;
  assign ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign clk_new  = wr_data[CLKSEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      clk_sel_q <= '0;
      freq_hi_q <= '0;
      freq_lo_q <= '0;
    end else begin
      if (wr_ok && wr_idx == IDX_CTRL) ctrl_q    <= ctrl_new;
      if (wr_ok && wr_idx == IDX_CLK)  clk_sel_q <= clk_new;
      if (freq_ok && wr_idx == IDX_FHI) freq_hi_q <= wr_data;
      if (freq_ok && wr_idx == IDX_FLO) freq_lo_q <= wr_data;
    end
  end

  // leaving mode-change with auto-calibrate requested
  assign cal_req = wr_ok && (wr_idx == IDX_CTRL) && ctrl_q.mce &&
                   !ctrl_new.mce && ctrl_new.acal_en;

  // clock selection changed and no bypass
  assign resync_req = wr_ok && (wr_idx == IDX_CLK) &&
                      (clk_new != clk_sel_q) && !ctrl_q.init_skip;

endmodule

// File: rtl/codec_calseq.sv
module codec_calseq
  import codec_modeseq_pkg::*;
#(
  parameter int CAL_TICKS = 384,
  parameter int ARM_TICKS = 2,
  parameter int OFF_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cal_req,
  output logic             cal_active,
  output logic             cal_busy,
  output logic             off_load,
  output logic [OFF_W-1:0] off_left,
  output logic [OFF_W-1:0] off_right
);

  localparam int CNT_MAX = (CAL_TICKS > ARM_TICKS) ? CAL_TICKS : ARM_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ARM_LAST = CNT_W'(ARM_TICKS - 1);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(CAL_TICKS - 1);
  localparam int NCH = 2;

  cal_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] stub_q;
  logic [OFF_W-1:0] stub_next;
  logic             done;

  assign done      = (state_q == CAL_RUN) && tick && (cnt_q == RUN_LAST);
  assign stub_next = stub_q + OFF_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CAL_ARM;  // calibrate after reset
      cnt_q    <= '0;
      stub_q   <= '0;
      off_load <= 1'b0;
    end else begin
      off_load <= 1'b0;
      unique case (state_q)
        CAL_IDLE: begin
          if (cal_req) begin
            state_q <= CAL_ARM;
            cnt_q   <= '0;
          end
        end
        CAL_ARM: begin
          if (tick) begin
            if (cnt_q == ARM_LAST) begin
              state_q <= CAL_RUN;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        CAL_RUN: begin
          if (tick) begin
            if (done) begin
              state_q  <= CAL_IDLE;
              cnt_q    <= '0;
              off_load <= 1'b1;
              stub_q   <= stub_next;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: begin
          state_q <= CAL_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  // per-channel offset store: left takes the stub, right its inverse
  logic [OFF_W-1:0] off_q [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q[ch] <= '0;
      end else if (done) begin
        off_q[ch] <= (ch == 0) ? stub_next : ~stub_next;
      end
    end
  end

  assign off_left   = off_q[0];
  assign off_right  = off_q[1];
  assign cal_active = (state_q != CAL_IDLE);
  assign cal_busy   = (state_q == CAL_RUN);

endmodule

// File: rtl/codec_resync.sv
module codec_resync #(
  parameter int RESYNC_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(RESYNC_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RESYNC_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end
    end else if (tick) begin
      if (cnt_q == LAST) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/codec_modeseq.sv
module codec_modeseq
  import codec_modeseq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CAL_TICKS    = 384,
  parameter int ARM_TICKS    = 2,
  parameter int RESYNC_TICKS = 10,
  parameter int OFF_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              compat_mode,
  input  logic              wr_en,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  output logic              xfer_fire,
  input  logic              adc_smp_valid,
  output logic              adc_out_valid,
  input  logic              dac_smp_valid,
  output logic              dac_take,
  output logic              cal_busy,
  output logic              resync_busy,
  output logic              off_load,
  output logic [OFF_W-1:0]  off_left,
  output logic [OFF_W-1:0]  off_right
);

  ctrl_t                 ctrl_q;
  logic [CLKSEL_W-1:0]   clk_sel_q;
  logic [DATA_W-1:0]     freq_hi_q;
  logic [DATA_W-1:0]     freq_lo_q;
  logic                  cal_req;
  logic                  resync_req;
  logic                  cal_active;
  reg_idx_e              idx;

  assign idx = reg_idx_e'(reg_idx);

  codec_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (idx),
    .wr_data    (wr_data),
    .compat_mode(compat_mode),
    .resync_busy(resync_busy),
    .ctrl_q     (ctrl_q),
    .clk_sel_q  (clk_sel_q),
    .freq_hi_q  (freq_hi_q),
    .freq_lo_q  (freq_lo_q),
    .cal_req    (cal_req),
    .resync_req (resync_req)
  );

  codec_calseq #(
    .CAL_TICKS(CAL_TICKS),
    .ARM_TICKS(ARM_TICKS),
    .OFF_W    (OFF_W)
  ) u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_tick),
    .cal_req   (cal_req),
    .cal_active(cal_active),
    .cal_busy  (cal_busy),
    .off_load  (off_load),
    .off_left  (off_left),
    .off_right (off_right)
  );

  codec_resync #(.RESYNC_TICKS(RESYNC_TICKS)) u_resync (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sample_tick),
    .start(resync_req),
    .busy (resync_busy)
  );

  // data-path gating
  assign xfer_ready    = !cal_active;
  assign xfer_fire     = xfer_valid && xfer_ready;
  assign adc_out_valid = adc_smp_valid && !cal_active;
  assign dac_take      = dac_smp_valid && !cal_active;

  // register readback
  always_comb begin
    rd_data = '0;
    if (resync_busy) begin
      rd_data = DATA_W'(SENTINEL);
    end else begin
      unique case (idx)
        IDX_CTRL: rd_data = DATA_W'(ctrl_q);
        IDX_CLK:  rd_data = DATA_W'(clk_sel_q);
        IDX_FHI:  rd_data = freq_hi_q;
        IDX_FLO:  rd_data = freq_lo_q;
        IDX_STAT: rd_data = DATA_W'(cal_busy) << STAT_BUSY_BIT;
        IDX_OFFL: rd_data = DATA_W'(off_left);
        IDX_OFFR: rd_data = DATA_W'(off_right);
        default:  rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/codec_modeseq_chk.sv
module codec_modeseq_chk #(
  parameter int DATA_W    = 8,
  parameter int CAL_TICKS = 384
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_tick,
  input logic              compat_mode,
  input logic              wr_en,
  input logic [2:0]        reg_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              xfer_ready,
  input logic              xfer_fire,
  input logic              adc_out_valid,
  input logic              dac_take,
  input logic              cal_busy,
  input logic              resync_busy,
  input logic              off_load,
  input logic [3:0]        ctrl_bits,
  input logic [3:0]        clk_bits,
  input logic [DATA_W-1:0] fhi_bits,
  input logic [DATA_W-1:0] flo_bits
);

  int run_ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_ticks_q <= 0;
    else if (!cal_busy)    run_ticks_q <= 0;
    else if (sample_tick)  run_ticks_q <= run_ticks_q + 1;
  end

  // R3
  cal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> run_ticks_q == CAL_TICKS);

  // R4
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !xfer_ready && !xfer_fire);

  // R5
  conv_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !adc_out_valid && !dac_take);

  // R6
  sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_busy |-> rd_data == DATA_W'(8'h80));

  // R6
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_busy |=> $stable({ctrl_bits, clk_bits, fhi_bits, flo_bits}));

  // R9
  compat_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compat_mode && wr_en && (reg_idx == 3'd2 || reg_idx == 3'd3)
      |=> $stable({fhi_bits, flo_bits}));

  // R10
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_load |=> !off_load);

  // R10
  load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> off_load);

endmodule

bind codec_modeseq codec_modeseq_chk #(
  .DATA_W   (DATA_W),
  .CAL_TICKS(CAL_TICKS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_tick  (sample_tick),
  .compat_mode  (compat_mode),
  .wr_en        (wr_en),
  .reg_idx      (reg_idx),
  .rd_data      (rd_data),
  .xfer_ready   (xfer_ready),
  .xfer_fire    (xfer_fire),
  .adc_out_valid(adc_out_valid),
  .dac_take     (dac_take),
  .cal_busy     (cal_busy),
  .resync_busy  (resync_busy),
  .off_load     (off_load),
  .ctrl_bits    (ctrl_q),
  .clk_bits     (clk_sel_q),
  .fhi_bits     (freq_hi_q),
  .flo_bits     (freq_lo_q)
);

// File: tb/codec_modeseq_bench.sv
module codec_modeseq_bench;

  localparam int CAL = 12;
  localparam int ARM = 3;
  localparam int RS  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] phase = 2'd0;
  logic       tick;
  logic       compat_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] reg_idx = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       xfer_valid = 1'b0, xfer_ready, xfer_fire;
  logic       adc_smp_valid = 1'b0, adc_out_valid;
  logic       dac_smp_valid = 1'b0, dac_take;
  logic       cal_busy, resync_busy, off_load;
  logic [7:0] off_left, off_right;

  always #2 clk = ~clk;
  always @(posedge clk) phase <= phase + 2'd1;
  assign tick = (phase == 2'd0);

  codec_modeseq #(.CAL_TICKS(CAL), .ARM_TICKS(ARM), .RESYNC_TICKS(RS)) u_codec_modeseq (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .compat_mode(compat_mode),
    .wr_en(wr_en), .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_fire(xfer_fire),
    .adc_smp_valid(adc_smp_valid), .adc_out_valid(adc_out_valid),
    .dac_smp_valid(dac_smp_valid), .dac_take(dac_take),
    .cal_busy(cal_busy), .resync_busy(resync_busy), .off_load(off_load),
    .off_left(off_left), .off_right(off_right));

  int errs = 0, checks = 0;
  int n_cal = 0, n_rs = 0, n_arm = 0, n_nrdy = 0;
  bit arm_flag = 1'b0;
  logic [7:0] exp_off = 8'd0;

  // tick and busy seen here are the values the next rising edge samples
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick && cal_busy)    n_cal++;
      if (tick && resync_busy) n_rs++;
      if (!xfer_ready)         n_nrdy++;
      if (arm_flag) begin
        if (cal_busy)  arm_flag = 1'b0;
        else if (tick) n_arm++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d, input bit arm);
    step;
    wr_en = 1'b1; reg_idx = idx; wr_data = d;
    if (arm) begin arm_flag = 1'b1; n_arm = 0; end
    step;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] v);
    reg_idx = idx;
    #1 v = rd_data;
  endtask

  task automatic finish_cal(input string tag);
    int base;
    base = n_cal;
    do step; while (!cal_busy);
    do step; while (cal_busy);
    exp_off = exp_off + 8'd1;
    chk(n_cal - base == CAL, {tag, " R3 busy ticks"}, n_cal - base, CAL);
    chk(off_load == 1'b1, {tag, " R10 load at fall"}, off_load, 1);
    chk(off_left == exp_off && off_right == ~exp_off, {tag, " R10 offsets"},
        off_left, exp_off);
    step;
    chk(off_load == 1'b0, {tag, " R10 load one cycle"}, off_load, 0);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    checks++; errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [3:0] cur_clk;
    logic [7:0] exp_hi, exp_lo;
    int base_c, base_r, base_n;

    repeat (3) step;
    // reset state
    rd(3'd0, v);
    chk(v == 8'h00, "R11 ctrl after reset", v, 0);
    rd(3'd1, v);
    chk(v == 8'h00, "R11 clksel after reset", v, 0);
    chk(!cal_busy && !resync_busy && !off_load, "R11 status after reset",
        {cal_busy, resync_busy, off_load}, 0);
    chk(!xfer_ready, "R4 arming in reset", xfer_ready, 0);
    rst_n = 1'b1;

    // R1 power-up calibration
    finish_cal("R1");
    rd(3'd5, v);
    chk(v == 8'h01, "R1 left readback", v, 1);
    rd(3'd6, v);
    chk(v == 8'hFE, "R1 right readback", v, 8'hFE);
    chk(xfer_ready, "R4 ready after cal", xfer_ready, 1);

    // R2 sweep of exit combinations
    xfer_valid = 1'b1; adc_smp_valid = 1'b1; dac_smp_valid = 1'b1;
    for (int c = 0; c < 8; c++) begin
      bit old_m, new_m, acal, trig;
      old_m = c[0]; new_m = c[1]; acal = c[2];
      trig  = old_m && !new_m && acal;
      wr(3'd0, {7'd0, old_m}, 1'b0);
      base_c = n_cal; base_n = n_nrdy;
      wr(3'd0, {6'd0, acal, new_m}, 1'b1);
      if (trig) begin
        chk(!xfer_ready && !xfer_fire, "R4 held while arming", xfer_ready, 0);
        do step; while (!cal_busy);
        chk(n_arm == ARM && n_arm <= 5, "R3 arm ticks", n_arm, ARM);
        chk(!xfer_fire && !adc_out_valid && !dac_take, "R5 masked in cal",
            {xfer_fire, adc_out_valid, dac_take}, 0);
        rd(3'd4, v);
        chk(v == 8'h20, "R11 status busy bit", v, 8'h20);
        finish_cal("R2");
        chk(xfer_fire && adc_out_valid && dac_take, "R5 released after cal",
            {xfer_fire, adc_out_valid, dac_take}, 7);
      end else begin
        arm_flag = 1'b0;
        repeat (40) step;
        chk(n_cal == base_c && n_nrdy == base_n, "R2 no calibration",
            n_cal - base_c, 0);
        rd(3'd5, v);
        chk(v == exp_off, "R2 offsets kept", v, exp_off);
      end
    end
    xfer_valid = 1'b0; adc_smp_valid = 1'b0; dac_smp_valid = 1'b0;

    // R6 sweep of clock selections
    wr(3'd0, 8'h00, 1'b0);
    cur_clk = 4'd0;
    for (int s = 0; s < 16; s++) begin
      base_r = n_rs;
      wr(3'd1, 8'(s), 1'b0);
      if (4'(s) != cur_clk) begin
        chk(resync_busy, "R6 window opens", resync_busy, 1);
        rd(3'd0, v);
        chk(v == 8'h80, "R6 sentinel read", v, 8'h80);
        wr(3'd0, 8'h08, 1'b0);
        while (resync_busy) step;
        chk(n_rs - base_r == RS, "R6 window length", n_rs - base_r, RS);
        rd(3'd0, v);
        chk(v == 8'h00, "R6 write dropped", v, 0);
      end else begin
        chk(!resync_busy && n_rs == base_r, "R7 same value no window",
            resync_busy, 0);
      end
      rd(3'd1, v);
      chk(v == 8'(s), "R11 clksel readback", v, s);
      cur_clk = 4'(s);
    end

    // R7 bypass
    wr(3'd0, 8'h04, 1'b0);
    base_r = n_rs;
    wr(3'd1, 8'h02, 1'b0);
    repeat (8) step;
    chk(!resync_busy && n_rs == base_r, "R7 bypass no window", n_rs - base_r, 0);
    rd(3'd1, v);
    chk(v == 8'h02, "R7 clksel taken", v, 2);

    // R8 and R9 frequency bytes
    exp_hi = 8'h00; exp_lo = 8'h00;
    for (int m = 0; m < 4; m++) begin
      bit cm, fe;
      cm = m[1]; fe = m[0];
      compat_mode = cm;
      wr(3'd0, fe ? 8'h08 : 8'h00, 1'b0);
      base_c = n_cal; base_r = n_rs; base_n = n_nrdy;
      wr(3'd2, 8'hA0 + 8'(m), 1'b0);
      wr(3'd3, 8'h50 + 8'(m), 1'b0);
      if (!cm && fe) begin exp_hi = 8'hA0 + 8'(m); exp_lo = 8'h50 + 8'(m); end
      repeat (8) step;
      rd(3'd2, v);
      chk(v == exp_hi, cm ? "R9 high byte" : "R8 high byte", v, exp_hi);
      rd(3'd3, v);
      chk(v == exp_lo, cm ? "R9 low byte" : "R8 low byte", v, exp_lo);
      chk(n_cal == base_c && n_rs == base_r && n_nrdy == base_n,
          "R8 no cal or window", n_cal - base_c + n_rs - base_r, 0);
    end
    compat_mode = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule